// File: doc/BRIEF.md
# Transactional Fully-Associative Data Cache

This block is a small fully-associative data cache placed between one processor core and a memory port shared with a second core. It serves 16-bit loads and stores. A hit answers one cycle after the request is taken. A miss holds the core in stall while the cache fills the line from memory. If the chosen victim is dirty, the cache first writes it back. Stores are write-back and write-allocate. Each line holds a full address tag, one data word, a valid bit, a dirty bit, a one-bit approximate recency stamp and a transaction mark.

The core pulses `txn_begin` when it installs a transaction-failure handler and `txn_commit` when it removes it. Between the two pulses, every line the cache touches is marked, and marked lines are never evicted. Two caches stay coherent over a pair of snoop links. Each cache announces its fills and stores on `snp_out_*`. When it sees a write from its partner on `snp_in_*`, it drops any matching line. If that line was marked, the cache raises `txn_fail` and keeps it high until commit. If a miss finds every line marked, the cache also raises `txn_fail` instead of evicting.

Top module: `txn_dcache`

## Requirements
- R1: After reset every line is invalid and `stall`, `resp_valid`, `txn_fail`, `mem_req` and `snp_out_valid` are low.
- R2: A request accepted while `stall` is low that matches a valid line answers with `resp_valid` high on the next cycle. `stall` stays low and no memory request is made. A load returns the stored word. A store returns its own write data, updates the line and makes it dirty.
- R3: On a miss, `stall` is high from the cycle after acceptance until the response. The fill is a memory read (`mem_write` low) of the requested address, and `mem_req`, `mem_addr` and `mem_write` are held until `mem_done`. With a port that answers in 4 cycles, a clean miss answers 5 cycles after acceptance. A load miss returns the memory word. A store miss installs its own data as a dirty line and does not write memory.
- R4: Each hit or fill sets the recency bit of the line it uses. If every valid line would then have its bit set, all other recency bits are cleared.
- R5: The victim is the lowest-indexed invalid line. If there is none, it is the lowest-indexed unmarked line with a clear recency bit. If there is none of those, it is the lowest-indexed unmarked line.
- R6: A dirty victim is written back before the fill. The write-back is a memory write (`mem_write` high) of the victim's address and data, and the miss then takes 10 cycles with a 4-cycle port. A clean victim causes no memory write.
- R7: Every fill and every store raises `snp_out_valid` for exactly the response cycle, with the request address and `snp_out_write` equal to 1 for a store and 0 for a load. A load hit raises nothing.
- R8: A snooped write (`snp_in_write` high) invalidates a matching line, so the next access to that address misses. A snooped read has no effect.
- R9: An access completed after a `txn_begin` pulse and before the next `txn_commit` pulse marks its line. Marked lines are never chosen as victims.
- R10: A snooped write that matches a marked line sets `txn_fail` on the next cycle.
- R11: A miss while all lines are marked sets `txn_fail` and answers on the next cycle with data 0. It makes no memory request, allocates no line and sends no snoop, and a store in that case is dropped.
- R12: `txn_fail` stays high until `txn_commit`. A commit pulse clears `txn_fail` and every mark on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core access request, taken when `stall` is low |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Store data |
| stall | output | 1 | Cache busy with a miss |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 16 | Load data, or store data for stores |
| txn_begin | input | 1 | Transaction start pulse |
| txn_commit | input | 1 | Transaction commit pulse |
| txn_fail | output | 1 | Sticky transaction failure |
| mem_req | output | 1 | Memory port request, held until done |
| mem_write | output | 1 | 1 for write-back, 0 for fill read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Fill data, valid with `mem_done` |
| mem_done | input | 1 | Memory operation complete |
| snp_out_valid | output | 1 | Snoop broadcast to the partner cache |
| snp_out_write | output | 1 | Broadcast is a store |
| snp_out_addr | output | 16 | Broadcast address |
| snp_in_valid | input | 1 | Snoop from the partner cache |
| snp_in_write | input | 1 | Partner access is a store |
| snp_in_addr | input | 16 | Partner access address |

## Verification
The cache is driven with a linear sweep that fills all eight lines and then hits each one. Store hits then dirty the lines, and a second sweep forces write-backs, which separates clean victims from dirty ones and checks the recency-clear rule through the victim order. A long pseudo-random mix of loads and stores over 32 addresses exercises hit, clean-miss and dirty-miss paths in arbitrary interleavings against a reference model of the line state. Transaction phases pair snooped writes and reads against marked and unmarked lines, and fill the whole cache with marked lines so that a miss must fail rather than evict.

// File: rtl/txn_dcache_pkg.sv
package txn_dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } dc_state_e;
endpackage

// File: rtl/dc_lookup.sv
module dc_lookup #(
  parameter int LINES = 8,
  parameter int AW    = 16,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_valid,
  input  logic [AW-1:0]    line_tag [LINES],
  input  logic [AW-1:0]    probe_addr,
  output logic             probe_hit,
  output logic [IW-1:0]    probe_idx
);
  logic [LINES-1:0] match_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match_vec[g] = line_valid[g] && (line_tag[g] == probe_addr);
  end

  always_comb begin
    probe_idx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (match_vec[i]) probe_idx = IW'(i);
  end
  assign probe_hit = |match_vec;

  // R8
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/dc_victim.sv
module dc_victim #(
  parameter int LINES = 8,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_valid,
  input  logic [LINES-1:0] line_lru,
  input  logic [LINES-1:0] line_txn,
  output logic             vic_found,
  output logic [IW-1:0]    vic_idx
);
  function automatic logic [LINES-1:0] lowest_bit(input logic [LINES-1:0] v);
    return v & (~v + LINES'(1));
  endfunction

  logic [LINES-1:0] free_vec, cold_vec, open_vec, sel_vec;
  assign free_vec = ~line_valid;
  assign cold_vec = line_valid & ~line_lru & ~line_txn;
  assign open_vec = line_valid & ~line_txn;

  always_comb begin
    if (|free_vec)      sel_vec = lowest_bit(free_vec);
    else if (|cold_vec) sel_vec = lowest_bit(cold_vec);
    else                sel_vec = lowest_bit(open_vec);
  end

  always_comb begin
    vic_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (sel_vec[i]) vic_idx = IW'(i);
  end
  assign vic_found = |sel_vec;

  // R5
  victim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));
  // R9
  victim_unmarked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_found |-> !(line_valid[vic_idx] && line_txn[vic_idx]));
endmodule

// File: rtl/txn_dcache.sv
module txn_dcache
  import txn_dcache_pkg::*;
#(
  parameter int LINES = 8,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          stall,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  input  logic          txn_begin,
  input  logic          txn_commit,
  output logic          txn_fail,
  output logic          mem_req,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done,
  output logic          snp_out_valid,
  output logic          snp_out_write,
  output logic [AW-1:0] snp_out_addr,
  input  logic          snp_in_valid,
  input  logic          snp_in_write,
  input  logic [AW-1:0] snp_in_addr
);
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;

  // recency update: set the used line, clear the rest once all valid are set
  function automatic logic [LINES-1:0] lru_touch(input logic [LINES-1:0] lru,
                                                 input logic [LINES-1:0] vld,
                                                 input logic [IW-1:0] idx);
    logic [LINES-1:0] t;
    t = lru;
    t[idx] = 1'b1;
    if ((t & vld) == vld) begin
      t = '0;
      t[idx] = 1'b1;
    end
    return t;
  endfunction

  logic [LINES-1:0] v_q, lru_q, dirty_q, txn_q;
  logic [AW-1:0]    tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES];

  dc_state_e     st_q;
  logic          rq_w_q;
  logic [AW-1:0] rq_a_q;
  logic [DW-1:0] rq_d_q;
  logic [IW-1:0] vic_q;
  logic          txn_on_q, fail_q, resp_q, so_v_q, so_w_q;
  logic [DW-1:0] rdata_q;
  logic [AW-1:0] so_a_q;

  // named internal events
  logic          req_hit, snp_hit, vic_found;
  logic [IW-1:0] hit_idx, snp_idx, vic_idx;
  logic          accept, acc_hit, acc_miss, wb_done, fill_done, snp_kill;

  dc_lookup #(.LINES(LINES), .AW(AW)) i_req_lookup (
    .clk(clk), .rst_n(rst_n), .line_valid(v_q), .line_tag(tag_q),
    .probe_addr(req_addr), .probe_hit(req_hit), .probe_idx(hit_idx));

  dc_lookup #(.LINES(LINES), .AW(AW)) i_snp_lookup (
    .clk(clk), .rst_n(rst_n), .line_valid(v_q), .line_tag(tag_q),
    .probe_addr(snp_in_addr), .probe_hit(snp_hit), .probe_idx(snp_idx));

  dc_victim #(.LINES(LINES)) i_victim (
    .clk(clk), .rst_n(rst_n), .line_valid(v_q), .line_lru(lru_q),
    .line_txn(txn_q), .vic_found(vic_found), .vic_idx(vic_idx));

  assign accept    = req_valid && (st_q == ST_IDLE);
  assign acc_hit   = accept && req_hit;
  assign acc_miss  = accept && !req_hit;
  assign wb_done   = (st_q == ST_WBACK) && mem_done;
  assign fill_done = (st_q == ST_FILL) && mem_done;
  assign snp_kill  = snp_in_valid && snp_in_write && snp_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      v_q <= '0; lru_q <= '0; dirty_q <= '0; txn_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
      rq_w_q <= 1'b0; rq_a_q <= '0; rq_d_q <= '0; vic_q <= '0;
      txn_on_q <= 1'b0; fail_q <= 1'b0; resp_q <= 1'b0; rdata_q <= '0;
      so_v_q <= 1'b0; so_w_q <= 1'b0; so_a_q <= '0;
    end else begin
      resp_q <= 1'b0;
      so_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (acc_hit) begin
            lru_q  <= lru_touch(lru_q, v_q, hit_idx);
            txn_q[hit_idx] <= txn_q[hit_idx] | txn_on_q;
            resp_q <= 1'b1;
            if (req_write) begin
              data_q[hit_idx]  <= req_wdata;
              dirty_q[hit_idx] <= 1'b1;
              rdata_q <= req_wdata;
              so_v_q  <= 1'b1;
              so_w_q  <= 1'b1;
              so_a_q  <= req_addr;
            end else begin
              rdata_q <= data_q[hit_idx];
            end
          end else if (acc_miss) begin
            rq_w_q <= req_write;
            rq_a_q <= req_addr;
            rq_d_q <= req_wdata;
            if (vic_found) begin
              vic_q <= vic_idx;
              st_q  <= (v_q[vic_idx] && dirty_q[vic_idx]) ? ST_WBACK : ST_FILL;
            end else begin
              fail_q  <= 1'b1;
              resp_q  <= 1'b1;
              rdata_q <= '0;
            end
          end
        end
        ST_WBACK: begin
          if (wb_done) begin
            dirty_q[vic_q] <= 1'b0;
            st_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_done) begin
            v_q[vic_q]     <= 1'b1;
            tag_q[vic_q]   <= rq_a_q;
            data_q[vic_q]  <= rq_w_q ? rq_d_q : mem_rdata;
            dirty_q[vic_q] <= rq_w_q;
            txn_q[vic_q]   <= txn_on_q;
            lru_q   <= lru_touch(lru_q, v_q | (LINES'(1) << vic_q), vic_q);
            resp_q  <= 1'b1;
            rdata_q <= rq_w_q ? rq_d_q : mem_rdata;
            so_v_q  <= 1'b1;
            so_w_q  <= rq_w_q;
            so_a_q  <= rq_a_q;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase

      if (snp_kill) begin
        v_q[snp_idx] <= 1'b0;
        if (txn_q[snp_idx]) fail_q <= 1'b1;
      end

      if (txn_commit) begin
        txn_on_q <= 1'b0;
        txn_q    <= '0;
        fail_q   <= 1'b0;
      end else if (txn_begin) begin
        txn_on_q <= 1'b1;
      end
    end
  end

  assign stall         = (st_q != ST_IDLE);
  assign mem_req       = (st_q != ST_IDLE);
  assign mem_write     = (st_q == ST_WBACK);
  assign mem_addr      = (st_q == ST_WBACK) ? tag_q[vic_q] : rq_a_q;
  assign mem_wdata     = data_q[vic_q];
  assign resp_valid    = resp_q;
  assign resp_rdata    = rdata_q;
  assign txn_fail      = fail_q;
  assign snp_out_valid = so_v_q;
  assign snp_out_write = so_w_q;
  assign snp_out_addr  = so_a_q;

  // R12
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fail && !txn_commit |=> txn_fail);
  // R12
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_commit |=> !txn_fail && (txn_q == '0));
  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_write));
  // R2
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> resp_valid && !stall);
  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> mem_req && !mem_write);
  // R10
  snoop_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill && txn_q[snp_idx] && !txn_commit |=> txn_fail);
endmodule

// File: tb/test_txn_dcache.sv
`timescale 1ns/1ps
module test_txn_dcache;
  localparam int LAT = 4;
  localparam int NL  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic stall, resp_valid, txn_fail;
  logic [15:0] resp_rdata;
  logic txn_begin = 0, txn_commit = 0;
  logic mem_req, mem_write, mem_done = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic snp_out_valid, snp_out_write;
  logic [15:0] snp_out_addr;
  logic snp_in_valid = 0, snp_in_write = 0;
  logic [15:0] snp_in_addr = '0;

  always #2.5 clk = ~clk;

  txn_dcache i_txn_dcache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .txn_begin(txn_begin),
    .txn_commit(txn_commit), .txn_fail(txn_fail), .mem_req(mem_req),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .snp_out_valid(snp_out_valid),
    .snp_out_write(snp_out_write), .snp_out_addr(snp_out_addr),
    .snp_in_valid(snp_in_valid), .snp_in_write(snp_in_write),
    .snp_in_addr(snp_in_addr));

  // memory with fixed latency and an operation log
  logic [15:0] mem [256];
  int cnt = 0;
  int op_n = 0;
  logic        op_w [4];
  logic [15:0] op_a [4];
  logic [15:0] op_d [4];

  always @(posedge clk) begin
    mem_done <= 1'b0;
    if (mem_req && !mem_done) begin
      if (cnt == LAT - 1) begin
        cnt <= 0;
        mem_done <= 1'b1;
        if (op_n < 4) begin
          op_w[op_n] <= mem_write;
          op_a[op_n] <= mem_addr;
          op_d[op_n] <= mem_wdata;
        end
        op_n <= op_n + 1;
        if (mem_write) mem[mem_addr[7:0]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:0]];
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  // reference model of line state
  logic        m_v [NL], m_l [NL], m_d [NL], m_x [NL];
  logic [15:0] m_t [NL], m_dat [NL];
  logic m_on = 0, m_fail = 0;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void m_touch(input int idx);
    bit all;
    m_l[idx] = 1'b1;
    all = 1;
    for (int i = 0; i < NL; i++) if (m_v[i] && !m_l[i]) all = 0;
    if (all) for (int i = 0; i < NL; i++) m_l[i] = (i == idx);
  endfunction

  task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d);
    int hi, vi, cyc, exp_cyc, exp_ops;
    bit wb, exp_so;
    logic [15:0] exp_rd, wb_a, wb_d;
    hi = -1; vi = -1; wb = 0; exp_so = 0; exp_cyc = 0; exp_ops = 0;
    wb_a = '0; wb_d = '0;
    for (int i = 0; i < NL; i++) if (m_v[i] && m_t[i] == a) hi = i;
    if (hi >= 0) begin
      exp_rd = w ? d : m_dat[hi];
      exp_so = w;
      if (w) begin m_dat[hi] = d; m_d[hi] = 1'b1; end
      if (m_on) m_x[hi] = 1'b1;
      m_touch(hi);
    end else begin
      for (int i = NL - 1; i >= 0; i--) if (!m_v[i]) vi = i;
      if (vi < 0) for (int i = NL - 1; i >= 0; i--) if (!m_l[i] && !m_x[i]) vi = i;
      if (vi < 0) for (int i = NL - 1; i >= 0; i--) if (!m_x[i]) vi = i;
      if (vi < 0) begin
        exp_rd = '0;
        m_fail = 1'b1;
      end else begin
        wb = m_v[vi] && m_d[vi];
        wb_a = m_t[vi]; wb_d = m_dat[vi];
        exp_ops = wb ? 2 : 1;
        exp_cyc = (LAT + 1) * exp_ops;
        exp_rd = w ? d : mem[a[7:0]];
        exp_so = 1;
        m_v[vi] = 1'b1; m_t[vi] = a; m_dat[vi] = exp_rd; m_d[vi] = w;
        m_x[vi] = m_on;
        m_touch(vi);
      end
    end
    op_n = 0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!resp_valid && cyc < 40) begin
      if (stall) cyc++;
      @(negedge clk);
    end
    if (hi >= 0) begin
      chk(cyc == 0 && !stall, "R2 hit latency", 32'(cyc), 0);
      chk(op_n == 0, "R2 hit memory ops", 32'(op_n), 0);
      chk(resp_rdata == exp_rd, "R2 hit data", resp_rdata, exp_rd);
    end else if (vi < 0) begin
      chk(cyc == 0 && op_n == 0, "R11 no-victim no memory", 32'(op_n), 0);
      chk(resp_rdata == 16'h0, "R11 no-victim data", resp_rdata, 0);
    end else begin
      chk(cyc == exp_cyc, wb ? "R6 dirty miss latency" : "R3 miss latency", 32'(cyc), 32'(exp_cyc));
      chk(op_n == exp_ops, "R6 memory op count", 32'(op_n), 32'(exp_ops));
      if (wb) begin
        chk(op_w[0] && op_a[0] == wb_a, "R5 victim write-back address", {op_w[0], op_a[0]}, {1'b1, wb_a});
        chk(op_d[0] == wb_d, "R6 write-back data", op_d[0], wb_d);
      end
      chk(!op_w[exp_ops-1] && op_a[exp_ops-1] == a, "R3 fill read address",
          {op_w[exp_ops-1], op_a[exp_ops-1]}, {1'b0, a});
      chk(resp_rdata == exp_rd, "R3 miss data", resp_rdata, exp_rd);
    end
    chk(snp_out_valid == exp_so, "R7 snoop out valid", snp_out_valid, exp_so);
    if (exp_so)
      chk(snp_out_write == w && snp_out_addr == a, "R7 snoop out fields",
          {snp_out_write, snp_out_addr}, {w, a});
    chk(txn_fail == m_fail, "R11 fail state after access", txn_fail, m_fail);
  endtask

  task automatic snoop(input logic w, input logic [15:0] a);
    snp_in_valid = 1'b1; snp_in_write = w; snp_in_addr = a;
    @(negedge clk);
    snp_in_valid = 1'b0;
    if (w) for (int i = 0; i < NL; i++)
      if (m_v[i] && m_t[i] == a) begin
        m_v[i] = 1'b0;
        if (m_x[i]) m_fail = 1'b1;
      end
    chk(txn_fail == m_fail, "R10 fail after snoop", txn_fail, m_fail);
  endtask

  task automatic begin_txn();
    txn_begin = 1'b1; @(negedge clk); txn_begin = 1'b0;
    m_on = 1'b1;
  endtask

  task automatic commit_txn();
    txn_commit = 1'b1; @(negedge clk); txn_commit = 1'b0;
    m_on = 1'b0; m_fail = 1'b0;
    for (int i = 0; i < NL; i++) m_x[i] = 1'b0;
    chk(txn_fail == 1'b0, "R12 commit clears fail", txn_fail, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + 16'(i * 7);
    for (int i = 0; i < NL; i++) begin
      m_v[i] = 0; m_l[i] = 0; m_d[i] = 0; m_x[i] = 0; m_t[i] = '0; m_dat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!stall && !resp_valid && !txn_fail && !mem_req && !snp_out_valid,
        "R1 reset outputs", {stall, resp_valid, txn_fail, mem_req, snp_out_valid}, 0);

    // R3 R4 fill all lines, then hit each
    for (int i = 0; i < 8; i++) access(1'b0, 16'h10 + 16'(i), '0);
    for (int i = 0; i < 8; i++) access(1'b0, 16'h10 + 16'(i), '0);
    // R2 store hits make lines dirty
    for (int i = 0; i < 8; i += 2) access(1'b1, 16'h10 + 16'(i), 16'hC000 + 16'(i));
    // R5 R6 evictions of dirty and clean lines
    for (int i = 0; i < 8; i++) access(1'b0, 16'h20 + 16'(i), '0);
    // R3 store miss allocates
    access(1'b1, 16'h30, 16'hBEEF);
    access(1'b0, 16'h30, '0);

    // R8 snooped write to unmarked line invalidates; snooped read ignored
    access(1'b0, 16'h21, '0);
    snoop(1'b0, 16'h21);
    access(1'b0, 16'h21, '0);
    snoop(1'b1, 16'h21);
    access(1'b0, 16'h21, '0);

    // R9 R10 transaction marks and snoop conflicts
    begin_txn();
    access(1'b0, 16'h22, '0);
    access(1'b1, 16'h23, 16'h1234);
    snoop(1'b0, 16'h22);
    chk(txn_fail == 1'b0, "R8 snooped read no fail", txn_fail, 0);
    snoop(1'b1, 16'h24);
    chk(txn_fail == 1'b0, "R10 unmarked snoop no fail", txn_fail, 0);
    snoop(1'b1, 16'h22);
    chk(txn_fail == 1'b1, "R10 marked snoop fail", txn_fail, 1);
    repeat (3) @(negedge clk);
    chk(txn_fail == 1'b1, "R12 fail sticky", txn_fail, 1);
    commit_txn();

    // R11 all lines marked
    begin_txn();
    for (int i = 0; i < 8; i++) access(1'b0, 16'h80 + 16'(i), '0);
    access(1'b0, 16'h90, '0);
    chk(txn_fail == 1'b1, "R11 no-victim fail", txn_fail, 1);
    access(1'b1, 16'h91, 16'hDEAD);
    commit_txn();
    access(1'b0, 16'h91, '0);
    chk(resp_rdata == 16'h5000 + 16'(16'h91 * 7), "R11 dropped store", resp_rdata, 16'h5000 + 16'(16'h91 * 7));

    // R9 partial transaction, marked lines survive a miss sweep
    begin_txn();
    access(1'b0, 16'h40, '0);
    access(1'b1, 16'h41, 16'h7777);
    for (int i = 0; i < 12; i++) access(1'b0, 16'hA0 + 16'(i), '0);
    access(1'b0, 16'h40, '0);
    access(1'b0, 16'h41, '0);
    commit_txn();

    // R2 R3 R4 R5 R6 pseudo-random mix
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access(lf[7], 16'h40 + 16'(lf[4:0]), lf ^ 16'h3C3C);
    end
    finish_run();
  end
endmodule